// File: doc/BRIEF.md
# USB Default Control Endpoint Sequencer

This block is the peripheral-side control logic for the default control endpoint of a USB device. The packet layer gives it token events that are already validated: a received setup packet with its direction bit, IN tokens and OUT data packets. Firmware gives it single-cycle command strobes: packet serviced, data end, send stall, load a transmit packet with a byte count, and write-one-to-clear for the two sticky error flags. The block tracks which phase of the control transfer is under way and reports it as one of three endpoint modes. It also produces a STALL handshake strobe, a transfer-complete strobe and a one-cycle interrupt pulse.

Every output is registered. A token or command presented at a clock edge is visible on the outputs from the next cycle. When a token and a firmware command arrive in the same cycle, the token is handled and the command is dropped. A bus reset, or the asynchronous reset, returns the block to idle with every flag clear.

Top module: `usb_ctrl_ep_seq`

## Requirements
- R1: After `rst_n` is low, or one cycle after `bus_reset` is high, `ep_mode` is 0 (idle) and `rx_ready`, `tx_ready`, `stall_sent`, `phase_abort`, `stall_hs`, `xfer_done` and `irq` are all 0.
- R2: `setup_rx` sets `rx_ready`, pulses `irq`, forces `ep_mode` to idle and latches `setup_dir_in`.
- R3: `fw_serviced` together with `fw_data_end` while in idle clears `rx_ready` and leaves the block in idle with a status stage pending that expects an IN token. That IN token pulses `xfer_done` and `irq` and ends the transfer. Any later token causes no interrupt.
- R4: `fw_serviced` without `fw_data_end` in idle moves `ep_mode` to 1 (transmit) when the latched direction is IN, or to 2 (receive) when it is OUT.
- R5: In transmit mode, an IN token with a loaded packet clears `tx_ready` and pulses `irq`. A full-size packet (`fw_tx_len` ≥ MAXP) loaded without data end keeps the endpoint in transmit mode.
- R6: A packet loaded with `fw_tx_len` < MAXP, or with `fw_data_end`, ends the transmit phase once it is sent: `ep_mode` returns to idle and the status stage expects an OUT token, which pulses `xfer_done`.
- R7: An OUT token or a setup packet that arrives in transmit mode sets `phase_abort`, pulses `irq` and returns the endpoint to idle.
- R8: After `fw_send_stall`, the next IN or OUT token pulses `stall_hs` and `irq`, sets `stall_sent` and returns the endpoint to idle.
- R9: Once data end has been given, a token in the data direction instead of the status direction pulses `stall_hs` and `irq` and sets `stall_sent`.
- R10: `stall_sent` and `phase_abort` stay set until a one-cycle `fw_clr_stall` or `fw_clr_abort` strobe clears them. A set in the same cycle wins over the clear.
- R11: In receive mode, an OUT data packet sets `rx_ready` and pulses `irq`. `fw_serviced` with `fw_data_end` returns the endpoint to idle, and the status stage then expects an IN token.
- R12: An IN token in transmit mode with no packet loaded is answered with NAK: no output changes and there is no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | USB bus reset seen, synchronous clear |
| setup_rx | input | 1 | 8-byte setup packet received |
| setup_dir_in | input | 1 | Direction of the setup request, 1 = device to host |
| in_tok | input | 1 | IN token addressed to this endpoint |
| out_tok | input | 1 | OUT data packet addressed to this endpoint |
| fw_serviced | input | 1 | Firmware has unloaded the received packet |
| fw_data_end | input | 1 | Firmware marks the last data packet or no data stage |
| fw_send_stall | input | 1 | Firmware asks for the next data or status request to be stalled |
| fw_tx_load | input | 1 | Firmware has loaded a transmit packet |
| fw_tx_len | input | $clog2(MAXP+1) | Byte count of the loaded packet |
| fw_clr_stall | input | 1 | Write-one-to-clear for stall_sent |
| fw_clr_abort | input | 1 | Write-one-to-clear for phase_abort |
| ep_mode | output | 2 | 0 idle, 1 transmit, 2 receive |
| rx_ready | output | 1 | A received setup or OUT packet waits for firmware |
| tx_ready | output | 1 | A transmit packet is loaded |
| stall_sent | output | 1 | A STALL handshake was sent (sticky) |
| phase_abort | output | 1 | The transmit phase was aborted by SETUP or OUT (sticky) |
| stall_hs | output | 1 | One-cycle strobe: answer the current token with STALL |
| xfer_done | output | 1 | One-cycle strobe: status stage completed |
| irq | output | 1 | One-cycle endpoint interrupt |

## Verification
The bench sweeps the transmit byte count over every value from 0 to the maximum packet size. Only the full-size count may keep the endpoint in transmit mode; an off-by-one in the short-packet compare would end a transfer one packet early or keep it waiting for a packet that never comes. The bench then sends the status token in each direction after each kind of data stage. A design that mixed up the status direction would report completion where a STALL is due, or stall a correct host. It also aborts the transmit phase with OUT and with SETUP, checks the NAK case with no packet loaded, and raises a clear together with a new stall to catch a wrong set/clear priority on the sticky flags.

// File: rtl/usb_ctrl_ep_seq.sv
module usb_ctrl_ep_seq #(
  parameter int MAXP = 64,
  localparam int LW = $clog2(MAXP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          setup_rx,
  input  logic          setup_dir_in,
  input  logic          in_tok,
  input  logic          out_tok,
  input  logic          fw_serviced,
  input  logic          fw_data_end,
  input  logic          fw_send_stall,
  input  logic          fw_tx_load,
  input  logic [LW-1:0] fw_tx_len,
  input  logic          fw_clr_stall,
  input  logic          fw_clr_abort,
  output logic [1:0]    ep_mode,
  output logic          rx_ready,
  output logic          tx_ready,
  output logic          stall_sent,
  output logic          phase_abort,
  output logic          stall_hs,
  output logic          xfer_done,
  output logic          irq
);
  localparam logic [1:0] M_IDLE = 2'd0, M_TX = 2'd1, M_RX = 2'd2;

  logic dir_in, stat_pend, stat_in, stall_pend, tx_last;
  wire  any_tok  = in_tok | out_tok;
  wire  tx_short = fw_tx_len < LW'(MAXP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_mode <= M_IDLE; rx_ready <= 1'b0; tx_ready <= 1'b0;
      stall_sent <= 1'b0; phase_abort <= 1'b0;
      stall_hs <= 1'b0; xfer_done <= 1'b0; irq <= 1'b0;
      dir_in <= 1'b0; stat_pend <= 1'b0; stat_in <= 1'b0;
      stall_pend <= 1'b0; tx_last <= 1'b0;
    end else begin
      irq <= 1'b0; stall_hs <= 1'b0; xfer_done <= 1'b0;
      if (fw_clr_stall) stall_sent <= 1'b0;
      if (fw_clr_abort) phase_abort <= 1'b0;
      if (bus_reset) begin
        ep_mode <= M_IDLE; rx_ready <= 1'b0; tx_ready <= 1'b0;
        stall_sent <= 1'b0; phase_abort <= 1'b0;
        dir_in <= 1'b0; stat_pend <= 1'b0; stat_in <= 1'b0;
        stall_pend <= 1'b0; tx_last <= 1'b0;
      end else if (setup_rx) begin
        rx_ready <= 1'b1; irq <= 1'b1; dir_in <= setup_dir_in;
        if (ep_mode == M_TX) phase_abort <= 1'b1;
        ep_mode <= M_IDLE; stat_pend <= 1'b0; stall_pend <= 1'b0; tx_ready <= 1'b0;
      end else if (any_tok && stall_pend) begin
        stall_hs <= 1'b1; stall_sent <= 1'b1; irq <= 1'b1;
        stall_pend <= 1'b0; stat_pend <= 1'b0; tx_ready <= 1'b0; ep_mode <= M_IDLE;
      end else if (ep_mode == M_TX && out_tok) begin
        phase_abort <= 1'b1; irq <= 1'b1; tx_ready <= 1'b0; ep_mode <= M_IDLE;
      end else if (ep_mode == M_IDLE && stat_pend && any_tok) begin
        stat_pend <= 1'b0; irq <= 1'b1;
        if (in_tok == stat_in) xfer_done <= 1'b1;
        else begin
          stall_hs <= 1'b1; stall_sent <= 1'b1;
        end
      end else if (ep_mode == M_TX && in_tok && tx_ready) begin
        tx_ready <= 1'b0; irq <= 1'b1;
        if (tx_last) begin
          ep_mode <= M_IDLE; stat_pend <= 1'b1; stat_in <= 1'b0;
        end
      end else if (ep_mode == M_RX && out_tok && !rx_ready) begin
        rx_ready <= 1'b1; irq <= 1'b1;
      end else if (!any_tok) begin
        if (fw_send_stall) stall_pend <= 1'b1;
        if (fw_serviced && rx_ready) begin
          rx_ready <= 1'b0;
          if (ep_mode == M_IDLE) begin
            if (fw_data_end) begin
              stat_pend <= 1'b1; stat_in <= 1'b1;
            end else ep_mode <= dir_in ? M_TX : M_RX;
          end else if (ep_mode == M_RX && fw_data_end) begin
            ep_mode <= M_IDLE; stat_pend <= 1'b1; stat_in <= 1'b1;
          end
        end
        if (fw_tx_load && ep_mode == M_TX && !tx_ready) begin
          tx_ready <= 1'b1; tx_last <= fw_data_end | tx_short;
        end
      end
    end
  end
endmodule

// File: rtl/usb_ctrl_ep_seq_chk.sv
module usb_ctrl_ep_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       fw_clr_stall,
  input logic [1:0] ep_mode,
  input logic       rx_ready,
  input logic       tx_ready,
  input logic       stall_sent,
  input logic       phase_abort,
  input logic       stall_hs,
  input logic       xfer_done,
  input logic       irq
);
  // R1
  bus_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_reset) |-> (ep_mode == 2'd0 && !rx_ready && !tx_ready && !stall_sent && !phase_abort && !irq));
  // R2
  rx_ready_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> irq);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (irq && ep_mode == 2'd0 && !stall_hs));
  // R7
  abort_from_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_abort) |-> ($past(ep_mode) == 2'd1 && ep_mode == 2'd0 && irq));
  // R8
  stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hs |-> (stall_sent && irq && ep_mode == 2'd0));
  // R10
  stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fw_clr_stall) |-> (!stall_sent || stall_hs));
  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_mode != 2'd3);
endmodule

bind usb_ctrl_ep_seq usb_ctrl_ep_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .fw_clr_stall(fw_clr_stall),
  .ep_mode(ep_mode), .rx_ready(rx_ready), .tx_ready(tx_ready),
  .stall_sent(stall_sent), .phase_abort(phase_abort), .stall_hs(stall_hs),
  .xfer_done(xfer_done), .irq(irq)
);

// File: tb/test_usb_ctrl_ep_seq.sv
`timescale 1ns/1ps
module test_usb_ctrl_ep_seq;
  localparam int MAXP = 8;
  localparam int LW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset, setup_rx, setup_dir_in, in_tok, out_tok;
  logic fw_serviced, fw_data_end, fw_send_stall, fw_tx_load, fw_clr_stall, fw_clr_abort;
  logic [LW-1:0] fw_tx_len;
  logic [1:0] ep_mode;
  logic rx_ready, tx_ready, stall_sent, phase_abort, stall_hs, xfer_done, irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_ctrl_ep_seq #(.MAXP(MAXP)) i_usb_ctrl_ep_seq (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .setup_rx(setup_rx),
    .setup_dir_in(setup_dir_in), .in_tok(in_tok), .out_tok(out_tok),
    .fw_serviced(fw_serviced), .fw_data_end(fw_data_end), .fw_send_stall(fw_send_stall),
    .fw_tx_load(fw_tx_load), .fw_tx_len(fw_tx_len), .fw_clr_stall(fw_clr_stall),
    .fw_clr_abort(fw_clr_abort), .ep_mode(ep_mode), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .stall_sent(stall_sent), .phase_abort(phase_abort),
    .stall_hs(stall_hs), .xfer_done(xfer_done), .irq(irq)
  );

  task automatic idle_in();
    bus_reset = 0; setup_rx = 0; setup_dir_in = 0; in_tok = 0; out_tok = 0;
    fw_serviced = 0; fw_data_end = 0; fw_send_stall = 0; fw_tx_load = 0;
    fw_tx_len = '0; fw_clr_stall = 0; fw_clr_abort = 0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); idle_in();
  endtask

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_setup(bit dir);
    setup_rx = 1; setup_dir_in = dir; cyc();
  endtask
  task automatic do_svc(bit dend);
    fw_serviced = 1; fw_data_end = dend; cyc();
  endtask
  task automatic do_load(int len, bit dend);
    fw_tx_load = 1; fw_tx_len = LW'(len); fw_data_end = dend; cyc();
  endtask
  task automatic do_in();
    in_tok = 1; cyc();
  endtask
  task automatic do_out();
    out_tok = 1; cyc();
  endtask

  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", ep_mode, 0); chk("R1 flags", {rx_ready, tx_ready, stall_sent, phase_abort, stall_hs, xfer_done, irq}, 0);
    rst_n = 1; @(negedge clk);

    // R2 setup
    do_setup(1);
    chk("R2 rx_ready", rx_ready, 1); chk("R2 irq", irq, 1); chk("R2 mode", ep_mode, 0);
    cyc(); chk("R2 irq one cycle", irq, 0);
    // R4 IN direction -> transmit
    do_svc(0);
    chk("R4 mode tx", ep_mode, 1); chk("R4 rx_ready", rx_ready, 0);
    // R12 IN with nothing loaded
    do_in();
    chk("R12 irq", irq, 0); chk("R12 mode", ep_mode, 1); chk("R12 tx_ready", tx_ready, 0);

    // R5/R6 sweep of every byte count
    for (int len = 0; len <= MAXP; len++) begin
      if (len != 0) begin do_setup(1); do_svc(0); end
      do_load(len, 0);
      chk("R5 tx_ready", tx_ready, 1);
      do_in();
      chk("R5 irq", irq, 1); chk("R5 tx_ready clr", tx_ready, 0);
      chk(len < MAXP ? "R6 short ends" : "R5 full stays", ep_mode, len < MAXP ? 0 : 1);
      if (len == MAXP) begin
        do_load(0, 0); do_in(); chk("R6 zero-length ends", ep_mode, 0);
      end
      do_out();
      chk("R6 status out done", xfer_done, 1); chk("R6 no stall", stall_hs, 0);
    end

    // R6/R9 full packet with data end, then host asks for more
    do_setup(1); do_svc(0); do_load(MAXP, 1); do_in();
    chk("R6 data end ends", ep_mode, 0);
    do_in();
    chk("R9 stall_hs", stall_hs, 1); chk("R9 stall_sent", stall_sent, 1); chk("R9 irq", irq, 1);
    cyc(); chk("R10 sticky", stall_sent, 1);
    fw_clr_stall = 1; cyc(); chk("R10 clear stall", stall_sent, 0);

    // R7 abort by OUT and by SETUP
    do_setup(1); do_svc(0); do_out();
    chk("R7 abort out", phase_abort, 1); chk("R7 mode", ep_mode, 0); chk("R7 irq", irq, 1);
    fw_clr_abort = 1; cyc(); chk("R10 clear abort", phase_abort, 0);
    do_setup(1); do_svc(0); do_load(3, 0); do_setup(0);
    chk("R7 abort setup", phase_abort, 1); chk("R7 rx_ready", rx_ready, 1); chk("R7 tx_ready", tx_ready, 0);
    fw_clr_abort = 1; cyc();

    // R3 zero-data request
    do_setup(0); do_svc(1);
    chk("R3 mode", ep_mode, 0); chk("R3 rx_ready", rx_ready, 0); chk("R3 irq quiet", irq, 0);
    do_in();
    chk("R3 done", xfer_done, 1); chk("R3 irq", irq, 1);
    do_in(); chk("R3 later token no irq", irq, 0); chk("R3 no stall", stall_sent, 0);

    // R11 receive data stage
    do_setup(0); do_svc(0);
    chk("R4 mode rx", ep_mode, 2);
    do_out(); chk("R11 rx_ready", rx_ready, 1); chk("R11 irq", irq, 1);
    do_svc(0); chk("R11 stays rx", ep_mode, 2); chk("R11 rx_ready clr", rx_ready, 0);
    do_out(); do_svc(1); chk("R11 ends", ep_mode, 0);
    do_out(); chk("R9 rx data dir stall", stall_hs, 1);
    fw_clr_stall = 1; cyc();
    do_setup(0); do_svc(0); do_out(); do_svc(1); do_in();
    chk("R11 status in done", xfer_done, 1);

    // R8 send stall
    do_setup(1); fw_serviced = 1; fw_send_stall = 1; cyc();
    chk("R8 pending quiet", stall_sent, 0);
    do_in();
    chk("R8 stall_hs", stall_hs, 1); chk("R8 stall_sent", stall_sent, 1); chk("R8 mode", ep_mode, 0);
    // R10 set wins over clear
    fw_send_stall = 1; cyc();
    in_tok = 1; fw_clr_stall = 1; cyc();
    chk("R10 set wins", stall_sent, 1);

    // R1 bus reset
    do_setup(1); do_svc(0); do_out();
    bus_reset = 1; cyc();
    chk("R1 bus reset mode", ep_mode, 0);
    chk("R1 bus reset flags", {rx_ready, tx_ready, stall_sent, phase_abort, irq}, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule